// File: doc/BRIEF.md
# Stereo Silence Flag Generator

This block watches the left and right signed sample words of a stereo audio path, one pair per sample strobe, and raises a single flag once both channels have stayed at exactly zero for a long unbroken run. The system uses the flag to drive an external mute during silence. Any nonzero word on either channel drops the flag on the next clock and starts the run count again from zero.

Two control inputs force the flag. While the timing-reset control is low, the flag is driven high, the run count is cleared, and the flag then stays high for a fixed number of sample strobes after the control returns high. While the active-low power-down input is low, the flag is held low and all state is cleared, whatever the timing-reset control is doing. All counting runs on the system clock and advances only on cycles where the sample strobe is high.

Top module: `zero_run_flag`

## Requirements
- R1: With power-down inactive (pwr_up_n = 1), no timing reset (tmg_run_n = 1) and no release window pending, the flag goes high in the clock cycle after the strobe that carries the ZERO_RUN-th (default 8192) consecutive sample pair in which both chan_l and chan_r equal zero, and not before.
- R2: A strobed sample pair in which chan_l or chan_r is nonzero drives the flag low in the next cycle and restarts the zero run from zero, so that ZERO_RUN further zero pairs are needed.
- R3: In every cycle after one where tmg_run_n is 0 (and pwr_up_n is 1), the flag is high.
- R4: After tmg_run_n returns to 1, the flag stays high for the next RELEASE_STB (default 5) strobes whatever their sample values, and goes low in the cycle after the RELEASE_STB-th of them; those samples do not count toward a zero run.
- R5: While pwr_up_n is 0 the flag is low, asynchronously, even when tmg_run_n is 0.
- R6: Zero pairs beyond the ZERO_RUN-th keep the flag high; the run count saturates and never exceeds ZERO_RUN.
- R7: Both power-down and timing reset discard a partial zero run, so a full ZERO_RUN of zero pairs is needed after either one before the flag rises.
- R8: Without a strobe, the flag can fall only through power-down; it never falls on a cycle that did not follow a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising-edge active |
| pwr_up_n | input | 1 | Active-low power-down; low clears all state and holds the flag low |
| tmg_run_n | input | 1 | Timing-reset control; 0 forces the flag high and clears the run count |
| smp_stb | input | 1 | One-cycle strobe marking a valid sample pair |
| chan_l | input | SMP_W (24) | Left channel sample, two's complement |
| chan_r | input | SMP_W (24) | Right channel sample, two's complement |
| zero_flag | output | 1 | High when silence is detected or timing reset is active |

## Verification
A run counter that is off by one, fails to clear, or wraps instead of saturating shows at the flag only at the end of a run, so the bench walks runs of exactly ZERO_RUN-1 and ZERO_RUN zero pairs and checks each strobe's result one cycle later. A release counter reloaded wrongly shows as the flag dropping one strobe early or late after timing reset, and a partial run surviving a reset shows as an early rise in the next run. Power-down dominance shows at once, since the flag must be low in the very next sample point.

// File: rtl/zero_run_flag.sv
module zero_run_flag #(
  parameter int SMP_W       = 24,
  parameter int ZERO_RUN    = 8192,
  parameter int RELEASE_STB = 5
) (
  input  logic             clk,
  input  logic             pwr_up_n,
  input  logic             tmg_run_n,
  input  logic             smp_stb,
  input  logic [SMP_W-1:0] chan_l,
  input  logic [SMP_W-1:0] chan_r,
  output logic             zero_flag
);

  localparam int CNT_W = $clog2(ZERO_RUN + 1);
  localparam int REL_W = $clog2(RELEASE_STB + 1);
  localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(ZERO_RUN);
  localparam logic [REL_W-1:0] REL_MAX = REL_W'(RELEASE_STB);

  logic [CNT_W-1:0] run_cnt;
  logic [REL_W-1:0] rel_cnt;
  logic             both_zero;
  logic [CNT_W-1:0] run_nxt;

  assign both_zero = (chan_l == '0) && (chan_r == '0);
  assign run_nxt   = (run_cnt == RUN_MAX) ? run_cnt : run_cnt + 1'b1;

  always_ff @(posedge clk or negedge pwr_up_n) begin
    if (!pwr_up_n) begin
      run_cnt   <= '0;
      rel_cnt   <= '0;
      zero_flag <= 1'b0;
    end else if (!tmg_run_n) begin
      run_cnt   <= '0;
      rel_cnt   <= REL_MAX;
      zero_flag <= 1'b1;
    end else if (smp_stb) begin
      if (rel_cnt != '0) begin
        rel_cnt <= rel_cnt - 1'b1;
        if (rel_cnt == REL_W'(1)) zero_flag <= 1'b0;
      end else if (both_zero) begin
        run_cnt   <= run_nxt;
        zero_flag <= (run_nxt == RUN_MAX);
      end else begin
        run_cnt   <= '0;
        zero_flag <= 1'b0;
      end
    end
  end

  // R1: a rise comes only from a completed run or from timing reset
  assert_rise_cause_R1: assert property (@(posedge clk) disable iff (!pwr_up_n)
    $rose(zero_flag) |-> (run_cnt == RUN_MAX) || $past(!tmg_run_n));

  // R2: nonzero sample outside the release window clears the flag
  assert_nonzero_clears_R2: assert property (@(posedge clk) disable iff (!pwr_up_n)
    (smp_stb && tmg_run_n && rel_cnt == '0 && (chan_l != '0 || chan_r != '0)) |=> !zero_flag);

  // R3: timing reset forces the flag high
  assert_tmg_forces_R3: assert property (@(posedge clk) disable iff (!pwr_up_n)
    !tmg_run_n |=> zero_flag);

  // R4: flag held high while the release window is open
  assert_release_high_R4: assert property (@(posedge clk) disable iff (!pwr_up_n)
    (rel_cnt != '0) |-> zero_flag);

  // R5: power-down holds the flag low
  assert_pd_low_R5: assert property (@(posedge clk)
    !pwr_up_n |-> !zero_flag);

  // R6: run count saturates
  assert_run_sat_R6: assert property (@(posedge clk) disable iff (!pwr_up_n)
    run_cnt <= RUN_MAX);

  // R8: a fall follows a strobe
  assert_fall_on_stb_R8: assert property (@(posedge clk) disable iff (!pwr_up_n)
    $fell(zero_flag) |-> $past(smp_stb));

endmodule

// File: tb/zero_run_flag_test.sv
module zero_run_flag_test;
  localparam int SMP_W = 24;
  localparam int ZRUN  = 8192;
  localparam int REL   = 5;

  typedef struct { bit exp; string tag; } item_t;

  logic clk = 1'b0;
  logic pwr_up_n = 1'b1;
  logic tmg_run_n = 1'b1;
  logic smp_stb = 1'b0;
  logic [SMP_W-1:0] chan_l = '0;
  logic [SMP_W-1:0] chan_r = '0;
  logic zero_flag;

  int total = 0;
  int bad = 0;
  item_t sb[$];
  logic took = 1'b0;
  int m_run = 0;
  int m_rel = 0;

  always #2.5 clk = ~clk;

  zero_run_flag #(.SMP_W(SMP_W), .ZERO_RUN(ZRUN), .RELEASE_STB(REL)) uut (
    .clk(clk), .pwr_up_n(pwr_up_n), .tmg_run_n(tmg_run_n), .smp_stb(smp_stb),
    .chan_l(chan_l), .chan_r(chan_r), .zero_flag(zero_flag));

  task automatic chk(input bit act, input bit exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: flag=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic send(input logic [SMP_W-1:0] l, input logic [SMP_W-1:0] r, input string tag);
    item_t it;
    @(negedge clk);
    chan_l = l; chan_r = r; smp_stb = 1'b1;
    if (m_rel > 0) begin
      m_rel--;
      it.exp = (m_rel != 0);
    end else if (l == 0 && r == 0) begin
      if (m_run < ZRUN) m_run++;
      it.exp = (m_run == ZRUN);
    end else begin
      m_run = 0;
      it.exp = 1'b0;
    end
    it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    smp_stb = 1'b0;
  endtask

  task automatic zeros(input int n, input string tag);
    for (int i = 0; i < n; i++) send('0, '0, tag);
  endtask

  always @(posedge clk) took <= smp_stb;

  always @(negedge clk) begin
    if (took) begin
      if (sb.size() == 0) begin
        total++; bad++;
        $display("FAIL scoreboard: result with no expected item");
      end else begin
        item_t it;
        it = sb.pop_front();
        chk(zero_flag, it.exp, it.tag);
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    total++; bad++;
    $display("FAIL watchdog: run did not complete, flag=%0b expected=done", zero_flag);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1 pwr_up_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(zero_flag, 1'b0, "R5 reset state");
    pwr_up_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: rise exactly at the ZRUN-th zero pair; R6: stays high beyond
    zeros(ZRUN, "R1");
    zeros(20, "R6");
    repeat (4) @(negedge clk);
    chk(zero_flag, 1'b1, "R6 idle hold");

    // R2: left nonzero, then right nonzero at end of a near-full run
    send(24'h000001, '0, "R2 left");
    zeros(ZRUN - 1, "R2");
    send('0, 24'h800000, "R2 right");
    zeros(ZRUN, "R2 rerun");

    // R3 / R4: timing reset then release window with nonzero data
    zeros(100, "R7 partial");
    @(negedge clk) tmg_run_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(zero_flag, 1'b1, "R3 forced");
    m_rel = REL; m_run = 0;
    tmg_run_n = 1'b1;
    @(negedge clk);
    chk(zero_flag, 1'b1, "R4 after release");
    for (int i = 0; i < REL; i++) send(24'h123456, 24'h7fffff, "R4");
    // R7: full run required after timing reset
    zeros(ZRUN, "R7 after tmg");

    // R5: power-down drops the flag and dominates timing reset
    @(negedge clk) pwr_up_n = 1'b0;
    #1 chk(zero_flag, 1'b0, "R5 pd");
    tmg_run_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(zero_flag, 1'b0, "R5 pd over tmg");
    tmg_run_n = 1'b1;
    @(negedge clk);
    pwr_up_n = 1'b1;
    m_run = 0; m_rel = 0;
    // R7: partial run then power-down discards it
    zeros(3000, "R7 pre");
    @(negedge clk) pwr_up_n = 1'b0;
    @(negedge clk) pwr_up_n = 1'b1;
    m_run = 0;
    zeros(ZRUN, "R7 after pd");
    // R8: no fall without a strobe
    repeat (6) @(negedge clk);
    chk(zero_flag, 1'b1, "R8 no strobe");

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule